// File: doc/BRIEF.md
# Transmit Power Index Limiter

This block turns two per-channel calibrated transmit levels (one for the CCK modulation, one for OFDM) into the final power indices that are written to the radio. When regulatory limiting is switched on, a maximum power given in whole dBm is converted into a separate index ceiling for each modulation. Each calibrated level that lies above its ceiling is pulled down to that ceiling. Both results are then held to a hard ceiling of 35.

A single start pulse launches a fixed write sequence on a simple strobe, address and data bus. The CCK index is written first. After a wait of about one millisecond, the OFDM index is written, followed straight away by the same tuning code to two OFDM tuning registers. A second wait of about one millisecond follows, and then a one-cycle done pulse marks the end. The tuning code depends on the final OFDM index. The wait is counted in clock cycles and derived from the clock frequency parameter.

Top module: `txpwr_limiter`

## Requirements
- R1: With regulatory limiting on, the OFDM ceiling is twice the dBm value, held within 0..40; an OFDM level above this ceiling is written as the ceiling (before R5 applies).
- R2: With regulatory limiting on, the CCK ceiling is four times the dBm value minus 52, held within 0..28; negative results give 0, and a CCK level above the ceiling is written as the ceiling.
- R3: With regulatory limiting on, a calibrated level at or below its ceiling is written unchanged.
- R4: With regulatory limiting off, max_dbm has no effect and levels are written as given (subject to R5).
- R5: Every written CCK or OFDM index is at most 35; larger values are written as 35.
- R6: Sequence after the start edge, with W = wait cycles: CCK write (address 0) in cycle 0, OFDM write (address 1) in cycle W+1, tuning A (address 2) in cycle W+2, tuning B (address 3) in cycle W+3, done high for one cycle in cycle 2W+4; no other write strobes.
- R7: Both tuning writes carry 0x54 when the final OFDM index is at most 17, and 0x50 otherwise.
- R8: A start pulse while busy is ignored; the running sequence keeps its captured values and produces one done.
- R9: After reset, wr_en, done and busy are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a sequence; inputs captured in this cycle |
| reg_en | input | 1 | Regulatory limiting enable |
| max_dbm | input | DBM_W | Regulatory maximum power in dBm (unsigned) |
| cck_level | input | LVL_W | Calibrated CCK level |
| ofdm_level | input | LVL_W | Calibrated OFDM level |
| wr_en | output | 1 | Register write strobe |
| wr_addr | output | 2 | 0 CCK index, 1 OFDM index, 2 tuning A, 3 tuning B |
| wr_data | output | LVL_W | Write data |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |

## Verification
The assertions assume that the input levels and max_dbm are only meaningful in the cycle start is high, since they are captured there and held. They also assume that start can arrive at any time, including mid-sequence. The stimulus changes inputs only at falling edges and pulses start for one cycle. One scenario deliberately raises start with different values during a wait, to show the captured values stay in force.

// File: rtl/txpwr_pkg.sv
// Shared types and constants for the transmit power index limiter.
// Assumes 8-bit register data; the tuning codes are fixed byte values.
package txpwr_pkg;
    typedef enum logic [1:0] {
        ADDR_CCK    = 2'd0,
        ADDR_OFDM   = 2'd1,
        ADDR_TUNE_A = 2'd2,
        ADDR_TUNE_B = 2'd3
    } reg_sel_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_W_CCK, ST_WAIT1, ST_W_OFDM, ST_W_TA, ST_W_TB, ST_WAIT2, ST_DONE
    } seq_st_e;

    localparam int MODE_CCK   = 0;
    localparam int MODE_OFDM  = 1;
    localparam int MODE_PLAIN = 2;

    localparam int LEVEL_CEIL  = 35;
    localparam int TUNE_THRESH = 17;
    localparam logic [7:0] TUNE_LOW_PWR  = 8'h54;
    localparam logic [7:0] TUNE_HIGH_PWR = 8'h50;
endpackage

// File: rtl/dbm_to_index.sv
// Converts an unsigned dBm value into a power index ceiling for one
// modulation: idx = dBm*MUL - OFS, held within 0..TOP. MODE picks the rule.
// Assumes DBM_W is small enough that 32-bit signed math cannot overflow.
module dbm_to_index #(
    parameter int DBM_W = 8,
    parameter int IDX_W = 8,
    parameter int MODE  = txpwr_pkg::MODE_OFDM
) (
    input  logic [DBM_W-1:0] dbm,
    output logic [IDX_W-1:0] idx
);
    import txpwr_pkg::*;

    localparam int MUL = (MODE == MODE_CCK) ? 4  : (MODE == MODE_OFDM) ? 2  : 1;
    localparam int OFS = (MODE == MODE_CCK) ? 52 : 0;
    localparam int TOP = (MODE == MODE_CCK) ? 28 : (MODE == MODE_OFDM) ? 40 : 35;

    logic signed [31:0] dbm_s;
    logic signed [31:0] scaled;

    // Scale and offset in signed arithmetic, then clamp to 0..TOP.
    always_comb begin
        dbm_s  = signed'(32'(dbm));
        scaled = dbm_s * MUL - OFS;
        if (scaled < 0)
            idx = '0;
        else if (scaled > TOP)
            idx = IDX_W'(TOP);
        else
            idx = IDX_W'(scaled);
    end
endmodule

// File: rtl/level_cap.sv
// Applies an optional ceiling to a calibrated level, then the fixed
// ceiling of 35. Purely combinational.
module level_cap #(
    parameter int LVL_W = 8
) (
    input  logic [LVL_W-1:0] level,
    input  logic [LVL_W-1:0] limit,
    input  logic             limit_en,
    output logic [LVL_W-1:0] capped
);
    import txpwr_pkg::*;

    logic [LVL_W-1:0] after_reg;

    // Regulatory cap first, fixed ceiling second.
    always_comb begin
        after_reg = (limit_en && (level > limit)) ? limit : level;
        capped    = (after_reg > LVL_W'(LEVEL_CEIL)) ? LVL_W'(LEVEL_CEIL) : after_reg;
    end
endmodule

// File: rtl/write_seq.sv
// Runs the four-write power programming sequence with two timed waits.
// Captures the final indices on start in idle; start while busy is ignored.
// Assumes WAIT_CYC >= 1.
module write_seq #(
    parameter int LVL_W    = 8,
    parameter int WAIT_CYC = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [LVL_W-1:0]      cck_idx,
    input  logic [LVL_W-1:0]      ofdm_idx,
    output logic                  wr_en,
    output txpwr_pkg::reg_sel_e   wr_sel,
    output logic [LVL_W-1:0]      wr_data,
    output logic                  busy,
    output logic                  done
);
    import txpwr_pkg::*;

    localparam int CW = (WAIT_CYC < 2) ? 1 : $clog2(WAIT_CYC);

    seq_st_e          st;
    logic [CW-1:0]    cnt;
    logic [LVL_W-1:0] cck_q, ofdm_q;
    logic [LVL_W-1:0] tune_code;
    logic             wait_end;

    assign wait_end = (cnt == CW'(WAIT_CYC - 1));

    // State, wait counter and captured indices.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            cnt    <= '0;
            cck_q  <= '0;
            ofdm_q <= '0;
        end else begin
            case (st)
                ST_IDLE: if (start) begin
                    cck_q  <= cck_idx;
                    ofdm_q <= ofdm_idx;
                    st     <= ST_W_CCK;
                end
                ST_W_CCK: begin cnt <= '0; st <= ST_WAIT1; end
                ST_WAIT1: if (wait_end) st <= ST_W_OFDM; else cnt <= cnt + 1'b1;
                ST_W_OFDM: st <= ST_W_TA;
                ST_W_TA:   st <= ST_W_TB;
                ST_W_TB:   begin cnt <= '0; st <= ST_WAIT2; end
                ST_WAIT2: if (wait_end) st <= ST_DONE; else cnt <= cnt + 1'b1;
                default:   st <= ST_IDLE;
            endcase
        end
    end

    // Tuning code chosen by the final OFDM index.
    always_comb tune_code = (ofdm_q <= LVL_W'(TUNE_THRESH)) ? LVL_W'(TUNE_LOW_PWR)
                                                           : LVL_W'(TUNE_HIGH_PWR);

    // Bus outputs decoded from state.
    always_comb begin
        wr_en   = 1'b1;
        wr_sel  = ADDR_CCK;
        wr_data = cck_q;
        case (st)
            ST_W_CCK:  ;
            ST_W_OFDM: begin wr_sel = ADDR_OFDM;   wr_data = ofdm_q;    end
            ST_W_TA:   begin wr_sel = ADDR_TUNE_A; wr_data = tune_code; end
            ST_W_TB:   begin wr_sel = ADDR_TUNE_B; wr_data = tune_code; end
            default:   begin wr_en = 1'b0; wr_data = '0; end
        endcase
    end

    assign busy = (st != ST_IDLE);
    assign done = (st == ST_DONE);

    assert_ceiling_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_sel == ADDR_CCK || wr_sel == ADDR_OFDM)) |-> (wr_data <= LVL_W'(LEVEL_CEIL)));
    assert_tune_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_sel == ADDR_TUNE_A || wr_sel == ADDR_TUNE_B)) |->
        (wr_data == LVL_W'(TUNE_LOW_PWR) || wr_data == LVL_W'(TUNE_HIGH_PWR)));
    assert_cck_then_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == ADDR_CCK) |=> !wr_en);
    assert_ofdm_then_tune_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == ADDR_OFDM) |=> (wr_en && wr_sel == ADDR_TUNE_A));
    assert_done_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!wr_en && busy));
    assert_hold_captured_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(cck_q) && $stable(ofdm_q)));
endmodule

// File: rtl/txpwr_limiter.sv
// Transmit power index limiter top: converts the regulatory dBm maximum to
// per-modulation ceilings, caps the calibrated levels and runs the write
// sequence. Wait length is WAIT_MS milliseconds at CLK_HZ.
module txpwr_limiter #(
    parameter int DBM_W   = 8,
    parameter int LVL_W   = 8,
    parameter int CLK_HZ  = 100_000_000,
    parameter int WAIT_MS = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             reg_en,
    input  logic [DBM_W-1:0] max_dbm,
    input  logic [LVL_W-1:0] cck_level,
    input  logic [LVL_W-1:0] ofdm_level,
    output logic             wr_en,
    output logic [1:0]       wr_addr,
    output logic [LVL_W-1:0] wr_data,
    output logic             busy,
    output logic             done
);
    import txpwr_pkg::*;

    localparam int RAW_WAIT = (CLK_HZ / 1000) * WAIT_MS;
    localparam int WAIT_CYC = (RAW_WAIT < 1) ? 1 : RAW_WAIT;

    logic [LVL_W-1:0] cck_lim, ofdm_lim, cck_fin, ofdm_fin;
    reg_sel_e         sel;

    dbm_to_index #(.DBM_W(DBM_W), .IDX_W(LVL_W), .MODE(MODE_CCK)) u_cck_conv (
        .dbm(max_dbm), .idx(cck_lim));
    dbm_to_index #(.DBM_W(DBM_W), .IDX_W(LVL_W), .MODE(MODE_OFDM)) u_ofdm_conv (
        .dbm(max_dbm), .idx(ofdm_lim));

    level_cap #(.LVL_W(LVL_W)) u_cck_cap (
        .level(cck_level), .limit(cck_lim), .limit_en(reg_en), .capped(cck_fin));
    level_cap #(.LVL_W(LVL_W)) u_ofdm_cap (
        .level(ofdm_level), .limit(ofdm_lim), .limit_en(reg_en), .capped(ofdm_fin));

    write_seq #(.LVL_W(LVL_W), .WAIT_CYC(WAIT_CYC)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cck_idx(cck_fin), .ofdm_idx(ofdm_fin),
        .wr_en(wr_en), .wr_sel(sel), .wr_data(wr_data),
        .busy(busy), .done(done));

    assign wr_addr = sel;
endmodule

// File: tb/txpwr_limiter_tb_top.sv
module txpwr_limiter_tb_top;
    localparam int W = 8;   // CLK_HZ 8000 with 1 ms wait

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       reg_en = 1'b0;
    logic [7:0] max_dbm = '0;
    logic [7:0] cck_level = '0;
    logic [7:0] ofdm_level = '0;
    logic       wr_en, busy, done;
    logic [1:0] wr_addr;
    logic [7:0] wr_data;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    txpwr_limiter #(.CLK_HZ(8000), .WAIT_MS(1)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .reg_en(reg_en),
        .max_dbm(max_dbm), .cck_level(cck_level), .ofdm_level(ofdm_level),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .busy(busy), .done(done));

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int clampi(input int v, input int lo, input int hi);
        return (v < lo) ? lo : (v > hi) ? hi : v;
    endfunction

    // One sequence; optionally a second start with other values at cycle 3.
    task automatic run(input string req, input bit ren, input int dbm,
                       input int cck, input int ofdm, input bit inject);
        int e_cck, e_ofdm, e_tune, writes, dones;
        e_cck  = cck;
        e_ofdm = ofdm;
        if (ren) begin
            e_cck  = (cck  > clampi(4*dbm - 52, 0, 28)) ? clampi(4*dbm - 52, 0, 28) : cck;
            e_ofdm = (ofdm > clampi(2*dbm, 0, 40))      ? clampi(2*dbm, 0, 40)      : ofdm;
        end
        e_cck  = (e_cck  > 35) ? 35 : e_cck;
        e_ofdm = (e_ofdm > 35) ? 35 : e_ofdm;
        e_tune = (e_ofdm <= 17) ? 8'h54 : 8'h50;
        writes = 0;
        dones  = 0;
        @(negedge clk);
        reg_en = ren; max_dbm = 8'(dbm); cck_level = 8'(cck); ofdm_level = 8'(ofdm);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int c = 0; c < 2*W + 8; c++) begin
            if (inject && c == 3) begin
                start = 1'b1; reg_en = 1'b0; cck_level = 8'd3; ofdm_level = 8'd30;
            end else begin
                start = 1'b0;
            end
            if (wr_en) writes++;
            if (done) begin
                dones++;
                check({req, " R6 done cycle"}, c, 2*W + 4);
            end
            if (c == 0) begin
                check({req, " R6 cck write"}, int'({wr_en, wr_addr}), 4);
                check({req, " cck index"}, wr_data, e_cck);
            end
            if (c == W + 1) begin
                check({req, " R6 ofdm write"}, int'({wr_en, wr_addr}), 5);
                check({req, " ofdm index"}, wr_data, e_ofdm);
            end
            if (c == W + 2) begin
                check({req, " R6 tune A"}, int'({wr_en, wr_addr}), 6);
                check({req, " R7 tune A data"}, wr_data, e_tune);
            end
            if (c == W + 3) begin
                check({req, " R6 tune B"}, int'({wr_en, wr_addr}), 7);
                check({req, " R7 tune B data"}, wr_data, e_tune);
            end
            if (c == 2*W + 5) check({req, " R6 idle after done"}, busy, 0);
            @(negedge clk);
        end
        check({req, " R6 write count"}, writes, 4);
        check({req, " R8 done count"}, dones, 1);
    endtask

    task automatic test_reset();
        check("R9 wr_en", wr_en, 0);
        check("R9 done", done, 0);
        check("R9 busy", busy, 0);
    endtask

    initial begin
        for (int i = 0; i < 100000; i++) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        run("R4 unlimited", 1'b0, 0, 20, 30, 1'b0);
        run("R5 ceiling", 1'b0, 0, 50, 60, 1'b0);
        run("R2 negative cck lim, R1 ofdm cap", 1'b1, 10, 12, 30, 1'b0);
        run("R2 cck cap, R7 thresh 17", 1'b1, 15, 12, 17, 1'b0);
        run("R3 below ceilings", 1'b1, 15, 5, 10, 1'b0);
        run("R2 R1 top clamps R5", 1'b1, 30, 50, 60, 1'b0);
        run("R1 zero dbm", 1'b1, 0, 0, 9, 1'b0);
        run("R7 ofdm 18", 1'b0, 0, 7, 18, 1'b0);
        run("R8 start while busy", 1'b1, 15, 12, 17, 1'b1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule